// File: doc/BRIEF.md
# Routed edge-triggered interrupt line bank

This block turns general-purpose pin levels into latched interrupt requests. Several ports each supply one pin per interrupt line. Pin n of every port is a candidate source for line n. A per-line select field picks which port drives the line. The chosen level is brought into the clock domain by a synchroniser. A change of that level is then classed as a rising or a falling edge. Each line has its own enable for each edge direction.

A qualifying edge latches the line's pending bit, but only when the line's mask bit is set. The bit stays latched until software writes a one to that line's clear strobe. The request outputs present the pending bits gated by the mask, and feed a separate vectored interrupt controller. Configuration arrives as register-level inputs held by the surrounding register file.

Top module: `irq_edge_ctrl`

## Requirements
- R1: Line n takes pin n of the port chosen by its select field `route_i[n*SEL_W +: SEL_W]`. Pin n of port p sits at bit `p*NUM_LINES + n` of `pins_i`.
- R2: A select value of NUM_PORTS or above feeds a constant low level to the line.
- R3: A low-to-high change of a line's source sets its pending bit when the line's bit in `rise_en_i` is 1. With that enable at 0, the change is ignored.
- R4: A high-to-low change sets the pending bit when the line's bit in `fall_en_i` is 1. With that enable at 0, the change is ignored. With both enables set, either direction sets the bit.
- R5: The source passes through a two-flop synchroniser. A pin change driven between clock edges shows in `pend_o` after the third rising clock edge, and not before.
- R6: An edge on a line whose `mask_i` bit is 0 does not set the pending bit.
- R7: A pending bit stays 1 until a cycle in which its `pend_clr_i` bit is 1. In that cycle it is cleared. A 0 in `pend_clr_i` leaves the bit unchanged.
- R8: When a qualifying edge and a clear of the same line land in the same cycle, the pending bit stays 1.
- R9: `irq_o` equals `pend_o` AND `mask_i`, bit by bit.
- R10: While `rst_n` is low, the pending bits, the request outputs and the synchroniser state are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PORTS*NUM_LINES | Pin levels, one group of NUM_LINES pins per port |
| route_i | input | NUM_LINES*SEL_W | Port select field for each line |
| rise_en_i | input | NUM_LINES | Rising-edge enable for each line |
| fall_en_i | input | NUM_LINES | Falling-edge enable for each line |
| mask_i | input | NUM_LINES | Interrupt mask for each line, 1 = enabled |
| pend_clr_i | input | NUM_LINES | Write-one-to-clear strobe for the pending bits |
| pend_o | output | NUM_LINES | Pending bits |
| irq_o | output | NUM_LINES | Interrupt requests to the vectored controller |

## Verification
The bound checker watches every cycle for the pending-register rules. A bit may become set only after a detected edge while the line is unmasked. A set bit may not drop without a clear. A clear that meets an edge must not win. No request may leave a masked line. Only the bench scenarios can show the routing itself, including the out-of-range select reading low. They also show which edge directions each enable admits, and the exact three-edge latency from pin to pending bit. Those checks need a known pin history that a per-cycle property cannot reconstruct.

// File: rtl/iec_pkg.sv
package iec_pkg;

   localparam int unsigned IEC_MIN_SYNC = 2;

   typedef enum logic [1:0] {
      EDGE_IDLE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10
   } edge_kind_e;

   function automatic edge_kind_e classify(input logic now_v, input logic was_v);
      if (now_v && !was_v)      return EDGE_RISE;
      else if (!now_v && was_v) return EDGE_FALL;
      else                      return EDGE_IDLE;
   endfunction

endpackage

// File: rtl/iec_port_mux.sv
module iec_port_mux #(
   parameter int unsigned NUM_PORTS = 4,
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned SEL_W     = 4
) (
   input  logic [NUM_PORTS*NUM_LINES-1:0] pins_i,
   input  logic [NUM_LINES*SEL_W-1:0]     route_i,
   output logic [NUM_LINES-1:0]           src_o
);

   localparam int unsigned PIN_W = NUM_PORTS * NUM_LINES;

   if (PIN_W < 1) begin : g_bad_pins
      $error("iec_port_mux: empty pin vector");
   end

   for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
      logic [SEL_W-1:0] sel;
      assign sel = route_i[ln*SEL_W +: SEL_W];

      if (NUM_PORTS == 1) begin : g_single
         assign src_o[ln] = (sel == '0) ? pins_i[ln] : 1'b0;
      end else begin : g_multi
         always_comb begin
            src_o[ln] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
               if (sel == SEL_W'(p)) src_o[ln] = pins_i[p*NUM_LINES + ln];
            end
         end
      end
   end

endmodule

// File: rtl/iec_sync.sv
module iec_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < iec_pkg::IEC_MIN_SYNC) begin : g_bad_stages
      $error("iec_sync: STAGES below the minimum of two");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= '0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/iec_edge_det.sv
module iec_edge_det
   import iec_pkg::*;
#(
   parameter int unsigned NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lvl_i,
   input  logic [NUM_LINES-1:0] rise_en_i,
   input  logic [NUM_LINES-1:0] fall_en_i,
   output logic [NUM_LINES-1:0] hit_o
);

   logic [NUM_LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
      edge_kind_e kind;
      assign kind = classify(lvl_i[ln], prev_q[ln]);
      always_comb begin
         unique case (kind)
            EDGE_RISE: hit_o[ln] = rise_en_i[ln];
            EDGE_FALL: hit_o[ln] = fall_en_i[ln];
            default:   hit_o[ln] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/iec_pend_reg.sv
module iec_pend_reg #(
   parameter int unsigned NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] hit_i,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic [NUM_LINES-1:0] clr_i,
   output logic [NUM_LINES-1:0] pend_o,
   output logic [NUM_LINES-1:0] irq_o
);

   logic [NUM_LINES-1:0] pend_q;
   logic [NUM_LINES-1:0] pend_d;

   for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
      always_comb begin
         if (hit_i[ln] && mask_i[ln]) pend_d[ln] = 1'b1;
         else if (clr_i[ln])          pend_d[ln] = 1'b0;
         else                         pend_d[ln] = pend_q[ln];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;
   assign irq_o  = pend_q & mask_i;

endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl #(
   parameter int unsigned NUM_PORTS   = 4,
   parameter int unsigned NUM_LINES   = 16,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PORTS*NUM_LINES-1:0] pins_i,
   input  logic [NUM_LINES*SEL_W-1:0]     route_i,
   input  logic [NUM_LINES-1:0]           rise_en_i,
   input  logic [NUM_LINES-1:0]           fall_en_i,
   input  logic [NUM_LINES-1:0]           mask_i,
   input  logic [NUM_LINES-1:0]           pend_clr_i,
   output logic [NUM_LINES-1:0]           pend_o,
   output logic [NUM_LINES-1:0]           irq_o
);

   localparam int unsigned MAX_PORTS = 1 << SEL_W;

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irq_edge_ctrl: NUM_LINES must be at least one");
   end
   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("irq_edge_ctrl: NUM_PORTS does not fit the select field");
   end

   logic [NUM_LINES-1:0] src_raw;
   logic [NUM_LINES-1:0] src_sync;
   logic [NUM_LINES-1:0] edge_hit;

   iec_port_mux #(
      .NUM_PORTS (NUM_PORTS),
      .NUM_LINES (NUM_LINES),
      .SEL_W     (SEL_W)
   ) u_mux (
      .pins_i  (pins_i),
      .route_i (route_i),
      .src_o   (src_raw)
   );

   iec_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_raw),
      .q_o   (src_sync)
   );

   iec_edge_det #(
      .NUM_LINES (NUM_LINES)
   ) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (src_sync),
      .rise_en_i (rise_en_i),
      .fall_en_i (fall_en_i),
      .hit_o     (edge_hit)
   );

   iec_pend_reg #(
      .NUM_LINES (NUM_LINES)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (edge_hit),
      .mask_i (mask_i),
      .clr_i  (pend_clr_i),
      .pend_o (pend_o),
      .irq_o  (irq_o)
   );

endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk #(
   parameter int unsigned NUM_LINES = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] mask,
   input logic [NUM_LINES-1:0] clr,
   input logic [NUM_LINES-1:0] hit,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] irq
);

   AST_NEW_PEND_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(mask)) == '0)); // R6

   AST_NEW_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R3

   AST_PEND_HOLDS_WITHOUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0)); // R7

   AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr) & $past(hit) & $past(mask) & ~pend) == '0)); // R8

   AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~mask) == '0)); // R9

   AST_IRQ_ONLY_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~pend) == '0)); // R9

endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(
   .NUM_LINES (NUM_LINES)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .mask  (mask_i),
   .clr   (pend_clr_i),
   .hit   (edge_hit),
   .pend  (pend_o),
   .irq   (irq_o)
);

// File: tb/tb_irq_edge_ctrl.sv
module tb_irq_edge_ctrl;

   localparam int unsigned NP = 3;
   localparam int unsigned NL = 4;
   localparam int unsigned SW = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP*NL-1:0] pins = '0;
   logic [NL*SW-1:0] route = '0;
   logic [NL-1:0]    rise = '0, fall = '0, mask = '0, clr = '0;
   logic [NL-1:0]    pend, irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_edge_ctrl #(
      .NUM_PORTS (NP), .NUM_LINES (NL), .SEL_W (SW), .SYNC_STAGES (2)
   ) dut (
      .clk (clk), .rst_n (rst_n), .pins_i (pins), .route_i (route),
      .rise_en_i (rise), .fall_en_i (fall), .mask_i (mask),
      .pend_clr_i (clr), .pend_o (pend), .irq_o (irq)
   );

   typedef struct packed {
      logic [15:0] route;
      logic [11:0] pins;
      logic [3:0]  rise;
      logic [3:0]  fall;
      logic [3:0]  mask;
      logic [3:0]  clr;
      logic [3:0]  exp;
   } vec_t;

   // Fields: route, pins, rise, fall, mask, clr, expected pending
   localparam vec_t VECS [12] = '{
      '{16'h0000, 12'h00F, 4'hF, 4'h0, 4'hF, 4'h0, 4'hF}, // R3 all rise
      '{16'h0000, 12'h00F, 4'hF, 4'h0, 4'hF, 4'hF, 4'h0}, // R7 clear
      '{16'h0000, 12'h000, 4'hF, 4'h0, 4'hF, 4'h0, 4'h0}, // R4 fall disabled
      '{16'h0000, 12'h00F, 4'h0, 4'h0, 4'hF, 4'h0, 4'h0}, // R3 rise disabled
      '{16'h0000, 12'h000, 4'h0, 4'hF, 4'hF, 4'h0, 4'hF}, // R4 fall
      '{16'h0000, 12'h000, 4'h0, 4'hF, 4'hF, 4'h5, 4'hA}, // R7 partial clear
      '{16'h0000, 12'h00F, 4'hF, 4'h0, 4'h3, 4'hA, 4'h3}, // R6 masked lines
      '{16'h0021, 12'h01F, 4'hF, 4'hF, 4'hF, 4'h3, 4'h2}, // R1 routing
      '{16'h7021, 12'h01F, 4'hF, 4'hF, 4'hF, 4'h0, 4'hA}, // R2 out of range
      '{16'h0000, 12'h000, 4'hF, 4'hF, 4'hF, 4'hA, 4'h5}, // R4 both edges
      '{16'h0000, 12'h00F, 4'hF, 4'hF, 4'h0, 4'h0, 4'h5}, // R6 R7 masked, held
      '{16'h0000, 12'h00F, 4'hF, 4'hF, 4'hF, 4'h0, 4'h5}  // R9 unmask
   };

   task automatic check(input string req, input logic [NL-1:0] got, input logic [NL-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset pend", pend, 4'h0);
      check("R10 reset irq", irq, 4'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      foreach (VECS[i]) begin
         route = VECS[i].route;
         pins  = VECS[i].pins;
         rise  = VECS[i].rise;
         fall  = VECS[i].fall;
         mask  = VECS[i].mask;
         clr   = VECS[i].clr;
         @(negedge clk);
         clr = '0;
         repeat (3) @(negedge clk);
         check($sformatf("R1-table vec %0d pend", i), pend, VECS[i].exp);
         check($sformatf("R9 vec %0d irq", i), irq, VECS[i].exp & VECS[i].mask);
      end

      // R5 latency: state pend=5, pins 0x00F, all enables and mask set
      clr = 4'hF;
      @(negedge clk);
      clr = '0;
      @(negedge clk);
      pins = 12'h00E;
      repeat (2) @(negedge clk);
      check("R5 not yet after two edges", pend, 4'h0);
      @(negedge clk);
      check("R5 set after third edge", pend, 4'h1);

      // R8 edge and clear in the same cycle
      pins = 12'h00F;
      repeat (2) @(negedge clk);
      clr = 4'h1;
      @(negedge clk);
      clr = '0;
      check("R8 edge wins over clear", pend, 4'h1);
      @(negedge clk);
      check("R7 held after R8", pend, 4'h1);

      // R10 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 reset clears pend", pend, 4'h0);
      check("R10 reset clears irq", irq, 4'h0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule